// File: doc/BRIEF.md
# Banked Activation Buffer Row with Diagonal Access

This block is one row of the on-chip buffer that feeds one row of a processing-element array. Storage is split into `NUM_BANKS` independent single-port memory banks, each `BANK_DEPTH` words deep and `DATA_W` bits wide. Three request ports reach the row. Port 0 and port 1 belong to the local PE row; for example, activations on one and weights on the other, held in separate banks. Port 2 is the diagonal path from the PE row one position above. That row uses it to fetch input activations from this row and to write output activations into it. Each request carries a write flag, a bank index, an address inside the bank, a padding flag and write data.

Each request port is a valid/ready stream. A request is taken on a rising clock edge where both valid and ready are high. Ready is computed from the requests presented in the same cycle. A requester that sees ready low must hold the request, unchanged, until it is taken; this hold is how a request that lost a conflict is replayed. Read results come back on a per-port response strobe with no back-pressure, exactly one cycle after the read was taken. They therefore stay in step with the PE configuration issued alongside the read. Reads of padding positions never touch a bank and return zero. The `stall` output shows that some presented request is being held back in the current cycle.

Top module: `act_buf_row`

## Requirements
- R1: While reset is held and in the first cycle after it, with no requests, `rsp_valid` is all zero and `stall` is low.
- R2: A read taken on a port produces `rsp_valid` for that same port exactly one cycle later. A port never raises `rsp_valid` in any other cycle.
- R3: A non-padding read returns the last value written to the same bank index and in-bank address. The bank index and address are separate fields, and different addresses in one bank hold independent values.
- R4: A bank serves at most one non-padding request per cycle. Requests aimed at different banks are all taken in the same cycle, on any mix of ports.
- R5: When a non-padding write and a non-padding read target the same bank in one cycle, the write is taken and the read's ready is low.
- R6: When two non-padding requests of the same kind (both reads or both writes) target one bank, the lower-numbered port is taken first. Port 0 ranks above port 1, and port 1 above port 2.
- R7: A padding read (pad flag 1, write flag 0) is always taken. It returns all-zero data with `rsp_valid` one cycle later, and it leaves its bank free for another port in the same cycle.
- R8: Port 2, the diagonal path, reads and writes every bank of this row under the same rules as the local ports.
- R9: A padding write (pad flag 1, write flag 1) is taken and discarded: the bank content at that address is unchanged.
- R10: `stall` is high in every cycle in which some port presents valid with ready low. A held request is taken in a later cycle once its bank is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 3 | Request valid, one bit per port (bit 2 = diagonal) |
| req_ready | output | 3 | Request ready, one bit per port |
| req_write | input | 3 | 1 = write, 0 = read, per port |
| req_pad | input | 3 | 1 = position lies in the padding area, per port |
| req_bank | input | 3*BANK_W | Bank index per port, port p at bits [p*BANK_W +: BANK_W] |
| req_addr | input | 3*ADDR_W | Word address inside the bank, per port |
| req_wdata | input | 3*DATA_W | Write data per port |
| rsp_valid | output | 3 | Read data valid per port, one cycle after the read is taken |
| rsp_data | output | 3*DATA_W | Read data per port; zero for padding reads |
| stall | output | 1 | High while any presented request is being held back |

## Verification
The bench builds the row with 4 banks of 16 words of 16 bits. With this size, three ports cover every kind of bank clash: write against read, read against read and write against write. It also allows all three ports to land on three distinct banks at once. The small depth keeps the reference model of the contents tiny while still letting two addresses in one bank be told apart. The 16-bit width gives each stored value a distinct pattern, so a response routed from the wrong bank or wrong address shows up as a data mismatch.

// File: rtl/acb_pkg.sv
package acb_pkg;
  // Fixed port roles of one buffer row.
  localparam int NUM_PORTS  = 3;
  localparam int PORT_LOC_A = 0;  // local PE row, first operand stream
  localparam int PORT_LOC_B = 1;  // local PE row, second operand stream
  localparam int PORT_DIAG  = 2;  // PE row above, diagonal path
  localparam int PORT_W     = $clog2(NUM_PORTS);
endpackage

// File: rtl/acb_bank.sv
module acb_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Single port: one access per cycle, read data registered.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/acb_bank_arbiter.sv
module acb_bank_arbiter #(
  parameter int NB = 8,
  parameter int NP = 3,
  localparam int BW = $clog2(NB),
  localparam int PW = $clog2(NP)
) (
  input  logic [NP-1:0]    valid,
  input  logic [NP-1:0]    write,
  input  logic [NP-1:0]    pad,
  input  logic [NP*BW-1:0] bank,
  output logic [NP-1:0]    grant,
  output logic [NB-1:0]    bank_en,
  output logic [NB*PW-1:0] bank_sel
);
  // Per bank: writers first, then readers; lower port index first.
  always_comb begin
    logic found;
    grant    = '0;
    bank_en  = '0;
    bank_sel = '0;
    for (int b = 0; b < NB; b++) begin
      found = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (!found && valid[p] && write[p] && !pad[p] &&
            bank[p*BW +: BW] == BW'(b)) begin
          found                = 1'b1;
          grant[p]             = 1'b1;
          bank_en[b]           = 1'b1;
          bank_sel[b*PW +: PW] = PW'(p);
        end
      end
      for (int p = 0; p < NP; p++) begin
        if (!found && valid[p] && !write[p] && !pad[p] &&
            bank[p*BW +: BW] == BW'(b)) begin
          found                = 1'b1;
          grant[p]             = 1'b1;
          bank_en[b]           = 1'b1;
          bank_sel[b*PW +: PW] = PW'(p);
        end
      end
    end
  end
endmodule

// File: rtl/acb_rsp_align.sv
module acb_rsp_align #(
  parameter int NB     = 8,
  parameter int NP     = 3,
  parameter int DATA_W = 32,
  localparam int BW    = $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        rd_take,
  input  logic [NP-1:0]        rd_pad,
  input  logic [NP*BW-1:0]     rd_bank,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  output logic [NP-1:0]        rsp_valid,
  output logic [NP*DATA_W-1:0] rsp_data
);
  logic [NP-1:0] vld_q;
  logic [NP-1:0] pad_q;
  logic [BW-1:0] bank_q [NP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      pad_q <= '0;
      for (int p = 0; p < NP; p++) bank_q[p] <= '0;
    end else begin
      vld_q <= rd_take;
      pad_q <= rd_pad & rd_take;
      for (int p = 0; p < NP; p++)
        if (rd_take[p]) bank_q[p] <= rd_bank[p*BW +: BW];
    end
  end

  // Each bank answers at most one port, so its registered output is that port's data.
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      if (vld_q[p] && !pad_q[p])
        rsp_data[p*DATA_W +: DATA_W] = bank_rdata[int'(bank_q[p])*DATA_W +: DATA_W];
      else
        rsp_data[p*DATA_W +: DATA_W] = '0;
    end
  end

  assign rsp_valid = vld_q;
endmodule

// File: rtl/act_buf_row.sv
module act_buf_row #(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 64,
  parameter int DATA_W     = 32,
  localparam int NP        = acb_pkg::NUM_PORTS,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W    = $clog2(BANK_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req_valid,
  output logic [NP-1:0]        req_ready,
  input  logic [NP-1:0]        req_write,
  input  logic [NP-1:0]        req_pad,
  input  logic [NP*BANK_W-1:0] req_bank,
  input  logic [NP*ADDR_W-1:0] req_addr,
  input  logic [NP*DATA_W-1:0] req_wdata,
  output logic [NP-1:0]        rsp_valid,
  output logic [NP*DATA_W-1:0] rsp_data,
  output logic                 stall
);
  localparam int PW = acb_pkg::PORT_W;

  logic [NP-1:0]               grant;
  logic [NUM_BANKS-1:0]        bank_en;
  logic [NUM_BANKS*PW-1:0]     bank_sel;
  logic [NUM_BANKS*DATA_W-1:0] bank_rdata;
  logic [NP-1:0]               rd_take;

  acb_bank_arbiter #(.NB(NUM_BANKS), .NP(NP)) u_arb (
    .valid    (req_valid),
    .write    (req_write),
    .pad      (req_pad),
    .bank     (req_bank),
    .grant    (grant),
    .bank_en  (bank_en),
    .bank_sel (bank_sel)
  );

  // Padding requests bypass the banks and are always accepted.
  assign req_ready = grant | req_pad;
  assign stall     = |(req_valid & ~req_ready);
  assign rd_take   = req_valid & req_ready & ~req_write;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wdata;
    logic              b_we;

    always_comb begin
      int unsigned s;
      s       = int'(bank_sel[b*PW +: PW]);
      b_addr  = req_addr[s*ADDR_W +: ADDR_W];
      b_wdata = req_wdata[s*DATA_W +: DATA_W];
      b_we    = req_write[s];
    end

    acb_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_mem (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (b_we),
      .addr  (b_addr),
      .wdata (b_wdata),
      .rdata (bank_rdata[b*DATA_W +: DATA_W])
    );
  end

  acb_rsp_align #(.NB(NUM_BANKS), .NP(NP), .DATA_W(DATA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_take    (rd_take),
    .rd_pad     (req_pad),
    .rd_bank    (req_bank),
    .bank_rdata (bank_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );
endmodule

// File: rtl/acb_checker.sv
module acb_checker #(
  parameter int NB = 8,
  parameter int NP = 3,
  parameter int BW = 3,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] req_valid,
  input logic [NP-1:0] req_ready,
  input logic [NP-1:0] req_write,
  input logic [NP-1:0] req_pad,
  input logic [NP*BW-1:0] req_bank,
  input logic [NP-1:0] rsp_valid,
  input logic [NP*DW-1:0] rsp_data,
  input logic          stall
);
  logic [NP-1:0] hits [NB];

  always_comb begin
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++)
        hits[b][p] = req_valid[p] && req_ready[p] && !req_pad[p] &&
                     req_bank[p*BW +: BW] == BW'(b);
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rsp_valid == '0);  // R1

  for (genvar b = 0; b < NB; b++) begin : g_b
    AST_ONE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hits[b]) <= 1);  // R4
  end

  for (genvar p = 0; p < NP; p++) begin : g_p
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_ready[p] && !req_write[p]) |=> rsp_valid[p]);  // R2
    AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> $past(req_valid[p] && req_ready[p] && !req_write[p]));  // R2
    AST_PAD_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_pad[p]) |-> req_ready[p]);  // R7
    AST_PAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_ready[p] && !req_write[p] && req_pad[p]) |=>
      (rsp_valid[p] && rsp_data[p*DW +: DW] == '0));  // R7
    AST_HELD_RAISES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_ready[p]) |-> stall);  // R10

    for (genvar q = 0; q < NP; q++) begin : g_q
      if (q != p) begin : g_wr
        AST_WRITE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
          (req_valid[p] && req_write[p] && !req_pad[p] &&
           req_valid[q] && !req_write[q] && !req_pad[q] &&
           req_bank[p*BW +: BW] == req_bank[q*BW +: BW]) |-> !req_ready[q]);  // R5
      end
      if (q > p) begin : g_lo
        AST_LOW_PORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
          (req_valid[p] && !req_pad[p] && req_valid[q] && !req_pad[q] &&
           req_write[p] == req_write[q] &&
           req_bank[p*BW +: BW] == req_bank[q*BW +: BW]) |-> !req_ready[q]);  // R6
      end
    end
  end
endmodule

bind act_buf_row acb_checker #(.NB(NUM_BANKS), .NP(NP), .BW(BANK_W), .DW(DATA_W)) u_acb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_pad   (req_pad),
  .req_bank  (req_bank),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .stall     (stall)
);

// File: tb/tb_act_buf_row.sv
module tb_act_buf_row;
  localparam int NB = 4, DEPTH = 16, DW = 16, BW = 2, AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    req_valid = '0, req_ready, req_write = '0, req_pad = '0;
  logic [3*BW-1:0] req_bank = '0;
  logic [3*AW-1:0] req_addr = '0;
  logic [3*DW-1:0] req_wdata = '0;
  logic [2:0]    rsp_valid;
  logic [3*DW-1:0] rsp_data;
  logic          stall;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  act_buf_row #(.NUM_BANKS(NB), .BANK_DEPTH(DEPTH), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_pad(req_pad), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .stall(stall)
  );

  // Staged request per port
  logic [2:0]    s_v = '0, s_w = '0, s_pd = '0;
  logic [BW-1:0] s_bank [3];
  logic [AW-1:0] s_addr [3];
  logic [DW-1:0] s_data [3];
  logic [DW-1:0] model [NB][DEPTH];

  // Scoreboard queues, one per port
  logic [DW-1:0] q0 [$], q1 [$], q2 [$];
  string t0 [$], t1 [$], t2 [$];

  task automatic put(input int p, input bit w, input bit pd, input int bank,
                     input int addr, input logic [DW-1:0] data);
    s_v[p] = 1'b1; s_w[p] = w; s_pd[p] = pd;
    s_bank[p] = BW'(bank); s_addr[p] = AW'(addr); s_data[p] = data;
  endtask

  task automatic push_exp(input int p, input logic [DW-1:0] d, input string t);
    case (p)
      0: begin q0.push_back(d); t0.push_back(t); end
      1: begin q1.push_back(d); t1.push_back(t); end
      default: begin q2.push_back(d); t2.push_back(t); end
    endcase
  endtask

  task automatic check_rsp(input int p, input logic [DW-1:0] got);
    logic [DW-1:0] e; string t; bit empty;
    empty = 1'b0;
    case (p)
      0: if (q0.size() == 0) empty = 1'b1; else begin e = q0.pop_front(); t = t0.pop_front(); end
      1: if (q1.size() == 0) empty = 1'b1; else begin e = q1.pop_front(); t = t1.pop_front(); end
      default: if (q2.size() == 0) empty = 1'b1; else begin e = q2.pop_front(); t = t2.pop_front(); end
    endcase
    checks++;
    if (empty) begin
      fails++;
      $display("FAIL R2 port %0d: rsp_valid with no read taken (got %h, expected none)", p, got);
    end else if (got !== e) begin
      fails++;
      $display("FAIL %s port %0d data: got %h expected %h", t, p, got, e);
    end
  endtask

  // One request cycle: drive after the falling edge, check ready/stall before the rising edge.
  task automatic step(input logic [2:0] exp_take, input bit exp_stall, input string tag);
    @(negedge clk);
    req_valid = s_v; req_write = s_w; req_pad = s_pd;
    for (int p = 0; p < 3; p++) begin
      req_bank[p*BW +: BW]  = s_bank[p];
      req_addr[p*AW +: AW]  = s_addr[p];
      req_wdata[p*DW +: DW] = s_data[p];
    end
    #1;
    checks++;
    if ((req_valid & req_ready) !== exp_take || stall !== exp_stall) begin
      fails++;
      $display("FAIL %s accept/stall: got take=%b stall=%b expected take=%b stall=%b",
               tag, req_valid & req_ready, stall, exp_take, exp_stall);
    end
    for (int p = 0; p < 3; p++)
      if (exp_take[p] && !s_w[p])
        push_exp(p, s_pd[p] ? '0 : model[s_bank[p]][s_addr[p]], tag);
    for (int p = 0; p < 3; p++)
      if (exp_take[p] && s_w[p] && !s_pd[p])
        model[s_bank[p]][s_addr[p]] = s_data[p];
    s_v = '0;
  endtask

  // Monitor: responses settle after the rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done)
      for (int p = 0; p < 3; p++)
        if (rsp_valid[p]) check_rsp(p, rsp_data[p*DW +: DW]);
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete (got timeout, expected completion)");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 3'b000 || stall !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: got rsp_valid=%b stall=%b expected 000/0", rsp_valid, stall);
    end
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    if (rsp_valid !== 3'b000 || stall !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: got rsp_valid=%b stall=%b expected 000/0", rsp_valid, stall);
    end

    // R4: writes to two different banks in one cycle
    put(0, 1, 0, 1, 3, 16'hA1A1); put(1, 1, 0, 2, 3, 16'hB2B2); step(3'b011, 0, "R4");
    // R3: read both back concurrently
    put(0, 0, 0, 1, 3, 0); put(1, 0, 0, 2, 3, 0); step(3'b011, 0, "R3");
    // R8: diagonal write into bank 1, another address
    put(2, 1, 0, 1, 4, 16'hC4C4); step(3'b100, 0, "R8");
    // R6: two reads on bank 1, port 0 first; R10 held port 2 then served
    put(0, 0, 0, 1, 4, 0); put(2, 0, 0, 1, 3, 0); step(3'b001, 1, "R6");
    put(2, 0, 0, 1, 3, 0); step(3'b100, 0, "R10");
    // R5: write on port 0 beats diagonal read on bank 2
    put(2, 0, 0, 2, 3, 0); put(0, 1, 0, 2, 5, 16'hD5D5); step(3'b001, 1, "R5");
    put(2, 0, 0, 2, 3, 0); step(3'b100, 0, "R10");
    // R5/R8: diagonal write beats lower-port read
    put(1, 0, 0, 1, 3, 0); put(2, 1, 0, 1, 6, 16'hE6E6); step(3'b100, 1, "R5");
    put(1, 0, 0, 1, 3, 0); step(3'b010, 0, "R10");
    // R7: padding read alongside a real read of the same bank
    put(0, 0, 1, 2, 3, 0); put(1, 0, 0, 2, 3, 0); step(3'b011, 0, "R7");
    // R9: padding write is discarded
    put(0, 1, 1, 1, 3, 16'hFFFF); step(3'b001, 0, "R9");
    put(0, 0, 0, 1, 3, 0); step(3'b001, 0, "R9");
    // R6: two writes to one bank, port 0 first, port 1 lands last
    put(0, 1, 0, 3, 0, 16'h1111); put(1, 1, 0, 3, 0, 16'h2222); step(3'b001, 1, "R6");
    put(1, 1, 0, 3, 0, 16'h2222); step(3'b010, 0, "R10");
    // R4/R8: three ports, three banks, all in one cycle
    put(0, 0, 0, 2, 5, 0); put(1, 0, 0, 1, 6, 0); put(2, 0, 0, 3, 0, 0); step(3'b111, 0, "R4");
    step(3'b000, 0, "idle");
    repeat (3) @(negedge clk);

    checks++;
    if (q0.size() + q1.size() + q2.size() != 0) begin
      fails++;
      $display("FAIL R2 missing responses: got %0d pending expected 0",
               q0.size() + q1.size() + q2.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule